// File: doc/BRIEF.md
# I2C Event Flag and Status Sequencer

This block sits between the byte-level machinery of an I2C-style two-wire controller and the software that drives it. The START/STOP generator, the byte shifter, the arbitration monitor and the own-address comparator each report what just happened on the bus through a one-cycle strobe. The sequencer picks the event to report, raises an interrupt flag and, one clock later, presents an 8-bit status code naming the event. While the flag is up it asks the clock generator to hold SCL low. The bus therefore stalls until software has read the status and written a 1 to the flag.

Software steers the next step through a control write. That write carries the flag-clear bit, the acknowledge-enable bit used when this side receives, and the START and STOP requests. The acknowledge-enable bit is driven out to the shifter. The START and STOP requests are held as pending outputs until the bus logic reports that it has carried them out. Bit shifting and SCL generation are not part of this block.

Top module: `i2c_evt_ctrl`

## Requirements
- R1: After reset, int_flag, scl_hold, ack_out, start_req and stop_req are 0 and status reads 0xF8.
- R2: An accepted event strobe sets int_flag and scl_hold at the next clock edge. In that first flagged cycle status still reads 0xF8. The event's code appears one edge later and stays until the flag is cleared.
- R3: A control write with ctl_clr=1 while int_flag is set clears int_flag and scl_hold at the next edge, and status returns to 0xF8 at that same edge. A control write with ctl_clr=0 leaves the flag set.
- R4: Whenever int_flag is 0, status reads 0xF8.
- R5: The master transmit codes are fixed. START sent gives 0x08 and repeated START sent gives 0x10. An address byte sent gives 0x18 with write and ACK, 0x20 with write and NACK, 0x40 with read and ACK, and 0x48 with read and NACK. addr_rw=1 means read and bus_ack=1 means ACK. A data byte sent gives 0x28 on ACK and 0x30 on NACK.
- R6: Arbitration loss gives 0x38 and wins over every other strobe in the same cycle. Below it the order is: STOP seen, START sent, repeated START sent, address sent, data sent, data received, own address, slave data.
- R7: Master data received gives 0x50 when ack_out is 1 and 0x58 when ack_out is 0.
- R8: Own address matched is reported only while ack_out is 1, as 0x60 for write (addr_rw=0) and 0xA8 for read. When ack_out is 0 the match is ignored and no flag is raised. Slave data received gives 0x80 when ack_out is 1 and 0x88 when it is 0. A STOP seen as slave gives 0xA0.
- R9: Event strobes that arrive while int_flag is set are ignored, and the status code already shown is kept.
- R10: Every control write loads ack_out from ctl_ack. ctl_start=1 sets start_req, which clears on the edge after a START or repeated START sent strobe. ctl_stop=1 sets stop_req, which clears on the edge after ev_stop_done. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start_sent | input | 1 | START has been driven on the bus |
| ev_rstart_sent | input | 1 | Repeated START has been driven on the bus |
| ev_addr_sent | input | 1 | Address byte sent and its acknowledge sampled |
| ev_data_sent | input | 1 | Data byte sent and its acknowledge sampled |
| ev_data_rcvd | input | 1 | Master has received a data byte |
| ev_arb_lost | input | 1 | Arbitration lost while acting as master |
| ev_own_addr | input | 1 | Own slave address received |
| ev_slv_data | input | 1 | Slave has received a data byte |
| ev_stop_seen | input | 1 | STOP or repeated START seen while addressed as slave |
| ev_stop_done | input | 1 | Requested STOP has been driven |
| bus_ack | input | 1 | Sampled acknowledge bit, 1 = ACK |
| addr_rw | input | 1 | Direction bit of the address byte, 1 = read |
| ctl_wr | input | 1 | Control write strobe |
| ctl_clr | input | 1 | Write 1 to clear the interrupt flag |
| ctl_ack | input | 1 | Acknowledge enable value |
| ctl_start | input | 1 | Request a START |
| ctl_stop | input | 1 | Request a STOP |
| int_flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| scl_hold | output | 1 | Request to hold SCL low |
| ack_out | output | 1 | Acknowledge enable to the shifter |
| start_req | output | 1 | Pending START request |
| stop_req | output | 1 | Pending STOP request |

## Verification
A wrong internal state appears at the ports within one or two clocks. A bad priority choice or ack-enable register shows up as a wrong status code on the second flagged cycle. A flag that sticks or drops early is seen on scl_hold in the very next cycle. A missing or extra delay on the status load shows as a non-idle code in the first flagged cycle, or an idle code in the second. The directed scenarios put each event under both acknowledge values, collide strobes in one cycle, and fire events at an already raised flag, so each of these faults reaches a port comparison.

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl #(
  parameter int unsigned STAT_W    = 8,
  parameter logic [7:0]  IDLE_CODE = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start_sent,
  input  logic              ev_rstart_sent,
  input  logic              ev_addr_sent,
  input  logic              ev_data_sent,
  input  logic              ev_data_rcvd,
  input  logic              ev_arb_lost,
  input  logic              ev_own_addr,
  input  logic              ev_slv_data,
  input  logic              ev_stop_seen,
  input  logic              ev_stop_done,
  input  logic              bus_ack,
  input  logic              addr_rw,
  input  logic              ctl_wr,
  input  logic              ctl_clr,
  input  logic              ctl_ack,
  input  logic              ctl_start,
  input  logic              ctl_stop,
  output logic              int_flag,
  output logic [STAT_W-1:0] status,
  output logic              scl_hold,
  output logic              ack_out,
  output logic              start_req,
  output logic              stop_req
);
  localparam logic [STAT_W-1:0] IDLE = STAT_W'(IDLE_CODE);

  logic              flag_q, load_q, ack_q, sreq_q, preq_q;
  logic [STAT_W-1:0] pend_q, stat_q, code;
  logic              hit;

  wire clr_req = ctl_wr & ctl_clr & flag_q;
  wire accept  = hit & ~flag_q;

  always_comb begin
    hit  = 1'b1;
    code = IDLE;
    if (ev_arb_lost)                 code = STAT_W'(8'h38);
    else if (ev_stop_seen)           code = STAT_W'(8'hA0);
    else if (ev_start_sent)          code = STAT_W'(8'h08);
    else if (ev_rstart_sent)         code = STAT_W'(8'h10);
    else if (ev_addr_sent)
      code = addr_rw ? (bus_ack ? STAT_W'(8'h40) : STAT_W'(8'h48))
                     : (bus_ack ? STAT_W'(8'h18) : STAT_W'(8'h20));
    else if (ev_data_sent)           code = bus_ack ? STAT_W'(8'h28) : STAT_W'(8'h30);
    else if (ev_data_rcvd)           code = ack_q ? STAT_W'(8'h50) : STAT_W'(8'h58);
    else if (ev_own_addr && ack_q)   code = addr_rw ? STAT_W'(8'hA8) : STAT_W'(8'h60);
    else if (ev_slv_data)            code = ack_q ? STAT_W'(8'h80) : STAT_W'(8'h88);
    else                             hit  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      load_q <= 1'b0;
      pend_q <= IDLE;
      stat_q <= IDLE;
    end else begin
      load_q <= accept;
      if (accept)       pend_q <= code;
      if (accept)       flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (clr_req)      stat_q <= IDLE;
      else if (load_q)  stat_q <= pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      sreq_q <= 1'b0;
      preq_q <= 1'b0;
    end else begin
      if (ctl_wr) ack_q <= ctl_ack;
      if (ctl_wr && ctl_start)                   sreq_q <= 1'b1;
      else if (ev_start_sent || ev_rstart_sent)  sreq_q <= 1'b0;
      if (ctl_wr && ctl_stop)                    preq_q <= 1'b1;
      else if (ev_stop_done)                     preq_q <= 1'b0;
    end
  end

  assign int_flag  = flag_q;
  assign scl_hold  = flag_q;
  assign status    = stat_q;
  assign ack_out   = ack_q;
  assign start_req = sreq_q;
  assign stop_req  = preq_q;
endmodule

module i2c_evt_ctrl_chk #(
  parameter int unsigned STAT_W    = 8,
  parameter logic [7:0]  IDLE_CODE = 8'hF8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              ctl_clr,
  input logic              ev_stop_done,
  input logic              ctl_stop,
  input logic              int_flag,
  input logic [STAT_W-1:0] status,
  input logic              scl_hold,
  input logic              stop_req
);
  localparam logic [STAT_W-1:0] IDLE = STAT_W'(IDLE_CODE);

  assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !int_flag |-> status == IDLE);

  assert_first_cycle_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_flag) && !(ctl_wr && ctl_clr)) |=> (status != IDLE && int_flag));

  assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && status != IDLE && !(ctl_wr && ctl_clr)) |=> ($stable(status) && int_flag));

  assert_clear_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && ctl_wr && ctl_clr) |=> (!int_flag && !scl_hold && status == IDLE));

  assert_hold_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> scl_hold);

  assert_stop_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop_done && !(ctl_wr && ctl_stop)) |=> !stop_req);
endmodule

bind i2c_evt_ctrl i2c_evt_ctrl_chk #(.STAT_W(STAT_W), .IDLE_CODE(IDLE_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_clr(ctl_clr),
  .ev_stop_done(ev_stop_done), .ctl_stop(ctl_stop), .int_flag(int_flag),
  .status(status), .scl_hold(scl_hold), .stop_req(stop_req)
);

// File: tb/i2c_evt_ctrl_bench.sv
module i2c_evt_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] ev = '0;
  logic bus_ack = 1'b0, addr_rw = 1'b0;
  logic ctl_wr = 1'b0, ctl_clr = 1'b0, ctl_ack = 1'b0, ctl_start = 1'b0, ctl_stop = 1'b0;
  logic int_flag, scl_hold, ack_out, start_req, stop_req;
  logic [7:0] status;
  logic cur_ack = 1'b0;
  int tests = 0, fails = 0;

  localparam int START = 0, RSTART = 1, ADDR = 2, DTX = 3, DRX = 4,
                 ARB = 5, OWN = 6, SLV = 7, STOPS = 8, STOPD = 9;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_evt_ctrl u_i2c_evt_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_start_sent(ev[START]), .ev_rstart_sent(ev[RSTART]), .ev_addr_sent(ev[ADDR]),
    .ev_data_sent(ev[DTX]), .ev_data_rcvd(ev[DRX]), .ev_arb_lost(ev[ARB]),
    .ev_own_addr(ev[OWN]), .ev_slv_data(ev[SLV]), .ev_stop_seen(ev[STOPS]),
    .ev_stop_done(ev[STOPD]), .bus_ack(bus_ack), .addr_rw(addr_rw),
    .ctl_wr(ctl_wr), .ctl_clr(ctl_clr), .ctl_ack(ctl_ack), .ctl_start(ctl_start),
    .ctl_stop(ctl_stop), .int_flag(int_flag), .status(status), .scl_hold(scl_hold),
    .ack_out(ack_out), .start_req(start_req), .stop_req(stop_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic clr, input logic ack, input logic st, input logic sp);
    ctl_wr = 1'b1; ctl_clr = clr; ctl_ack = ack; ctl_start = st; ctl_stop = sp;
    cur_ack = ack;
    @(posedge clk); @(negedge clk);
    ctl_wr = 1'b0; ctl_clr = 1'b0; ctl_start = 1'b0; ctl_stop = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] m, input logic ack, input logic rw);
    ev = m; bus_ack = ack; addr_rw = rw;
    @(posedge clk); @(negedge clk);
    ev = '0;
  endtask

  task automatic clear_flag(input string tag);
    wr(1'b1, cur_ack, 1'b0, 1'b0);
    chk({tag, " R3 flag cleared"}, int_flag, 0);
    chk({tag, " R3 scl released"}, scl_hold, 0);
    chk({tag, " R4 status idle"}, status, 8'hF8);
  endtask

  task automatic do_event(input string tag, input logic [9:0] m, input logic ack,
                          input logic rw, input logic [7:0] exp);
    pulse(m, ack, rw);
    chk({tag, " R2 flag set"}, int_flag, 1);
    chk({tag, " R2 scl held"}, scl_hold, 1);
    chk({tag, " R2 first cycle idle"}, status, 8'hF8);
    @(negedge clk);
    chk(tag, status, exp);
    chk({tag, " R2 still held"}, scl_hold, 1);
    clear_flag(tag);
  endtask

  task automatic t_reset;
    chk("R1 int_flag", int_flag, 0);
    chk("R1 status", status, 8'hF8);
    chk("R1 scl_hold", scl_hold, 0);
    chk("R1 ack_out", ack_out, 0);
    chk("R1 start_req", start_req, 0);
    chk("R1 stop_req", stop_req, 0);
  endtask

  task automatic t_master_tx;
    do_event("R5 start", 10'(1 << START), 0, 0, 8'h08);
    do_event("R5 addr W ack", 10'(1 << ADDR), 1, 0, 8'h18);
    do_event("R5 addr W nack", 10'(1 << ADDR), 0, 0, 8'h20);
    do_event("R5 addr R ack", 10'(1 << ADDR), 1, 1, 8'h40);
    do_event("R5 addr R nack", 10'(1 << ADDR), 0, 1, 8'h48);
    do_event("R5 data ack", 10'(1 << DTX), 1, 0, 8'h28);
    do_event("R5 data nack", 10'(1 << DTX), 0, 0, 8'h30);
    do_event("R5 rstart", 10'(1 << RSTART), 0, 0, 8'h10);
  endtask

  task automatic t_priority;
    do_event("R6 arb over data", 10'((1 << ARB) | (1 << DTX) | (1 << START)), 1, 0, 8'h38);
    do_event("R6 stop over start", 10'((1 << STOPS) | (1 << START)), 0, 0, 8'hA0);
    do_event("R6 start over addr", 10'((1 << START) | (1 << ADDR)), 1, 0, 8'h08);
    do_event("R6 addr over data", 10'((1 << ADDR) | (1 << DTX)), 1, 1, 8'h40);
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    do_event("R6 drx over own", 10'((1 << DRX) | (1 << OWN)), 0, 0, 8'h50);
  endtask

  task automatic t_master_rx;
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 ack_out set", ack_out, 1);
    do_event("R7 rx ack", 10'(1 << DRX), 0, 0, 8'h50);
    wr(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 ack_out cleared", ack_out, 0);
    do_event("R7 rx nack", 10'(1 << DRX), 0, 0, 8'h58);
  endtask

  task automatic t_slave;
    wr(1'b0, 1'b0, 1'b0, 1'b0);
    pulse(10'(1 << OWN), 0, 0);
    chk("R8 own ignored flag", int_flag, 0);
    @(negedge clk);
    chk("R8 own ignored status", status, 8'hF8);
    chk("R8 own ignored scl", scl_hold, 0);
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    do_event("R8 own write", 10'(1 << OWN), 0, 0, 8'h60);
    do_event("R8 own read", 10'(1 << OWN), 0, 1, 8'hA8);
    do_event("R8 slave data ack", 10'(1 << SLV), 0, 0, 8'h80);
    wr(1'b0, 1'b0, 1'b0, 1'b0);
    do_event("R8 slave data nack", 10'(1 << SLV), 0, 0, 8'h88);
    do_event("R8 stop seen", 10'(1 << STOPS), 0, 0, 8'hA0);
  endtask

  task automatic t_busy;
    pulse(10'(1 << DTX), 1, 0);
    @(negedge clk);
    chk("R9 first code", status, 8'h28);
    pulse(10'(1 << ARB), 0, 0);
    @(negedge clk); @(negedge clk);
    chk("R9 code kept", status, 8'h28);
    chk("R9 flag kept", int_flag, 1);
    wr(1'b0, cur_ack, 1'b0, 1'b0);
    chk("R3 no clear without bit", int_flag, 1);
    chk("R3 scl still held", scl_hold, 1);
    clear_flag("R3 busy end");
    @(negedge clk);
    chk("R9 event not replayed", int_flag, 0);
  endtask

  task automatic t_requests;
    wr(1'b0, cur_ack, 1'b1, 1'b0);
    chk("R10 start_req set", start_req, 1);
    pulse(10'(1 << START), 0, 0);
    chk("R10 start_req cleared", start_req, 0);
    clear_flag("R10 start");
    wr(1'b0, cur_ack, 1'b0, 1'b1);
    chk("R10 stop_req set", stop_req, 1);
    @(negedge clk);
    chk("R10 stop_req waits", stop_req, 1);
    pulse(10'(1 << STOPD), 0, 0);
    chk("R10 stop_req cleared", stop_req, 0);
    chk("R10 stop_done no flag", int_flag, 0);
    ev[STOPD] = 1'b1;
    wr(1'b0, cur_ack, 1'b0, 1'b1);
    ev = '0;
    chk("R10 set wins over clear", stop_req, 1);
    pulse(10'(1 << STOPD), 0, 0);
    chk("R10 stop_req final", stop_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_master_tx;
    t_priority;
    t_master_rx;
    t_slave;
    t_busy;
    t_requests;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule